// File: doc/BRIEF.md
# Display Serial Packet Assembler

This block turns one packet request into the ordered byte stream of a display serial link packet. A request carries a two-bit virtual channel, a six-bit data type, a sixteen-bit field and a format flag. In short format the sixteen-bit field holds two data bytes. In long format it is a word count, and that many payload bytes are then pulled from a valid/ready byte source. The block adds the header error-correction byte, and for long packets it adds a sixteen-bit CRC footer.

The output is a valid/ready byte stream with a last flag, meant to feed a lane distributor. Start and end of transmission, lane splitting and serialisation belong to later stages. The block handles one packet at a time. It takes a new request only after the last byte of the previous packet has been accepted downstream. Payload bytes pass straight from the source to the output with no buffering, so a stall on either side stalls both.

Top module: `pkt_asm_top`

## Requirements
- R1: The first byte of every packet is the identifier byte: `reqChan` in bits 7:6 and `reqType` in bits 5:0.
- R2: A short packet (`reqLong`=0) is four bytes: identifier, `reqWord[7:0]`, `reqWord[15:8]`, error-correction byte. `outLast` is high only on the fourth byte.
- R3: A long packet (`reqLong`=1) sends the identifier, then the word count low byte, the word count high byte and the error-correction byte. It then forwards exactly word-count payload bytes in arrival order, followed by two footer bytes. `outLast` is high only on the second footer byte.
- R4: With `reqCrcEn`=1 the footer is a CRC sent low byte first. The register starts at FFFFh. For each payload byte, the byte is XORed into bits 7:0 and the register is then shifted right eight times, XORing 8408h after any shift whose outgoing bit was 1.
- R5: A long packet with word count 0 and `reqCrcEn`=1 is six bytes, and its footer bytes are FFh, FFh.
- R6: With `reqCrcEn`=0 both footer bytes are 00h, whatever the payload.
- R7: The error-correction byte is computed over the 24 bits D = {byte 2, byte 1, identifier}, where D0 is identifier bit 0. Bit i (i = 0 to 5) is the XOR of the bits of D selected by mask i: F12CB7h, F2555Bh, 749A6Dh, B8E38Eh, DF03F0h, EFFC00h. Bits 7:6 are always 0.
- R8: `plReady` is high only during the payload phase of a long packet. No payload byte is consumed outside that phase, so a source that keeps offering bytes loses none beyond the word count.
- R9: After reset, `reqReady`=1, `outValid`=0 and `plReady`=0. `reqReady` stays low from the accepted request until the last byte has been accepted, and a request offered meanwhile is ignored.
- R10: While `outValid`=1 and `outReady`=0, the next cycle keeps `outValid`, `outData` and `outLast` unchanged, provided the payload source holds its byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Packet request offered |
| reqReady | output | 1 | Block idle, request taken when valid |
| reqLong | input | 1 | 1 = long format, 0 = short format |
| reqChan | input | 2 | Virtual channel |
| reqType | input | 6 | Data type |
| reqWord | input | 16 | Two data bytes (short) or payload byte count (long) |
| reqCrcEn | input | 1 | 1 = compute footer CRC, 0 = send zero footer |
| plValid | input | 1 | Payload byte offered |
| plReady | output | 1 | Payload byte taken when valid |
| plData | input | 8 | Payload byte |
| outValid | output | 1 | Output byte valid |
| outReady | input | 1 | Downstream accepts the byte |
| outData | output | 8 | Output byte |
| outLast | output | 1 | Final byte of the packet |

## Verification
The identifier byte shows on `outData` in the first cycle after the clock edge that accepts a request. Each further header and footer byte follows one cycle after the edge at which the previous byte was accepted. A payload byte appears on the output in the same cycle it is offered, because that path is combinational. The bench changes its inputs just after a falling edge and samples one time unit later, still before the next rising edge. It scores a byte only when `outValid` and `outReady` are both high at that point, since that is the byte the coming edge will transfer. A held byte is compared at the next sample. The payload consumed is counted from `plValid && plReady` at the same sample points and compared with the word count once the packet ends.

// File: rtl/pkt_asm_pkg.sv
package pkt_asm_pkg;

  localparam int BYTE_W = 8;
  localparam int WC_W   = 2 * BYTE_W;
  localparam int HDR_W  = 3 * BYTE_W;
  localparam int CRC_W  = 16;
  localparam int PAR_N  = 6;

  typedef enum logic [2:0] {
    SEL_DI,
    SEL_LO,
    SEL_HI,
    SEL_ECC,
    SEL_PAY,
    SEL_CK0,
    SEL_CK1,
    SEL_NONE
  } byteSel_e;

  typedef struct packed {
    logic     capture;
    logic     payStep;
    byteSel_e sel;
  } ctrlStrobe_t;

  function automatic logic [HDR_W-1:0] parityMask(input int idx);
    logic [HDR_W-1:0] m;
    case (idx)
      0:       m = 24'hF12CB7;
      1:       m = 24'hF2555B;
      2:       m = 24'h749A6D;
      3:       m = 24'hB8E38E;
      4:       m = 24'hDF03F0;
      default: m = 24'hEFFC00;
    endcase
    return m;
  endfunction

  function automatic logic [BYTE_W-1:0] headerEcc(input logic [HDR_W-1:0] hdr);
    logic [BYTE_W-1:0] e;
    e = '0;
    for (int i = 0; i < PAR_N; i++) begin
      e[i] = ^(hdr & parityMask(i));
    end
    return e;
  endfunction

  function automatic logic [CRC_W-1:0] crcStep(input logic [CRC_W-1:0] cur,
                                                input logic [BYTE_W-1:0] b,
                                                input logic [CRC_W-1:0] poly);
    logic [CRC_W-1:0] r;
    r = cur ^ {{(CRC_W-BYTE_W){1'b0}}, b};
    for (int i = 0; i < BYTE_W; i++) begin
      r = r[0] ? ((r >> 1) ^ poly) : (r >> 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/pkt_asm_ctrl.sv
module pkt_asm_ctrl
  import pkt_asm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqLong,
  input  logic        outReady,
  input  logic        plValid,
  input  logic        wcZero,
  input  logic        remOne,
  output logic        reqReady,
  output logic        outValid,
  output logic        outLast,
  output logic        plReady,
  output ctrlStrobe_t strb
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_DI, ST_LO, ST_HI, ST_ECC, ST_PAY, ST_CK0, ST_CK1
  } state_e;

  state_e stateQ, stateD;
  logic   longQ;
  logic   beat;

  always_comb begin
    reqReady     = (stateQ == ST_IDLE);
    plReady      = (stateQ == ST_PAY) && outReady;
    outValid     = (stateQ == ST_PAY) ? plValid : (stateQ != ST_IDLE);
    outLast      = (stateQ == ST_CK1) || ((stateQ == ST_ECC) && !longQ);
    beat         = outValid && outReady;
    strb.capture = reqReady && reqValid;
    strb.payStep = (stateQ == ST_PAY) && plValid && outReady;
    case (stateQ)
      ST_DI:   strb.sel = SEL_DI;
      ST_LO:   strb.sel = SEL_LO;
      ST_HI:   strb.sel = SEL_HI;
      ST_ECC:  strb.sel = SEL_ECC;
      ST_PAY:  strb.sel = SEL_PAY;
      ST_CK0:  strb.sel = SEL_CK0;
      ST_CK1:  strb.sel = SEL_CK1;
      default: strb.sel = SEL_NONE;
    endcase
  end

  always_comb begin
    stateD = stateQ;
    case (stateQ)
      ST_IDLE: if (reqValid) stateD = ST_DI;
      ST_DI:   if (beat) stateD = ST_LO;
      ST_LO:   if (beat) stateD = ST_HI;
      ST_HI:   if (beat) stateD = ST_ECC;
      ST_ECC:  if (beat) stateD = !longQ ? ST_IDLE : (wcZero ? ST_CK0 : ST_PAY);
      ST_PAY:  if (strb.payStep && remOne) stateD = ST_CK0;
      ST_CK0:  if (beat) stateD = ST_CK1;
      ST_CK1:  if (beat) stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      longQ  <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (strb.capture) longQ <= reqLong;
    end
  end

endmodule

// File: rtl/pkt_asm_dpath.sv
module pkt_asm_dpath
  import pkt_asm_pkg::*;
#(
  parameter logic [CRC_W-1:0] CRC_SEED = 16'hFFFF,
  parameter logic [CRC_W-1:0] CRC_POLY = 16'h8408
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strb,
  input  logic [1:0]        reqChan,
  input  logic [5:0]        reqType,
  input  logic [WC_W-1:0]   reqWord,
  input  logic              reqCrcEn,
  input  logic [BYTE_W-1:0] plData,
  output logic [BYTE_W-1:0] outData,
  output logic              wcZero,
  output logic              remOne
);

  logic [BYTE_W-1:0] diQ;
  logic [WC_W-1:0]   wordQ;
  logic [WC_W-1:0]   remQ;
  logic [CRC_W-1:0]  crcQ;
  logic              crcEnQ;
  logic [CRC_W-1:0]  footer;
  logic [BYTE_W-1:0] eccByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      diQ    <= '0;
      wordQ  <= '0;
      remQ   <= '0;
      crcQ   <= CRC_SEED;
      crcEnQ <= 1'b0;
    end else if (strb.capture) begin
      diQ    <= {reqChan, reqType};
      wordQ  <= reqWord;
      remQ   <= reqWord;
      crcQ   <= CRC_SEED;
      crcEnQ <= reqCrcEn;
    end else if (strb.payStep) begin
      remQ <= remQ - WC_W'(1);
      crcQ <= crcStep(crcQ, plData, CRC_POLY);
    end
  end

  always_comb begin
    eccByte = headerEcc({wordQ, diQ});
    footer  = crcEnQ ? crcQ : '0;
    wcZero  = (wordQ == '0);
    remOne  = (remQ == WC_W'(1));
    case (strb.sel)
      SEL_DI:  outData = diQ;
      SEL_LO:  outData = wordQ[BYTE_W-1:0];
      SEL_HI:  outData = wordQ[WC_W-1:BYTE_W];
      SEL_ECC: outData = eccByte;
      SEL_PAY: outData = plData;
      SEL_CK0: outData = footer[BYTE_W-1:0];
      SEL_CK1: outData = footer[CRC_W-1:BYTE_W];
      default: outData = '0;
    endcase
  end

endmodule

// File: rtl/pkt_asm_top.sv
module pkt_asm_top
  import pkt_asm_pkg::*;
#(
  parameter logic [15:0] CRC_SEED = 16'hFFFF,
  parameter logic [15:0] CRC_POLY = 16'h8408
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic        reqLong,
  input  logic [1:0]  reqChan,
  input  logic [5:0]  reqType,
  input  logic [15:0] reqWord,
  input  logic        reqCrcEn,
  input  logic        plValid,
  output logic        plReady,
  input  logic [7:0]  plData,
  output logic        outValid,
  input  logic        outReady,
  output logic [7:0]  outData,
  output logic        outLast
);

  ctrlStrobe_t strb;
  logic        wcZero;
  logic        remOne;

  pkt_asm_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqLong  (reqLong),
    .outReady (outReady),
    .plValid  (plValid),
    .wcZero   (wcZero),
    .remOne   (remOne),
    .reqReady (reqReady),
    .outValid (outValid),
    .outLast  (outLast),
    .plReady  (plReady),
    .strb     (strb)
  );

  pkt_asm_dpath #(
    .CRC_SEED (CRC_SEED),
    .CRC_POLY (CRC_POLY)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .reqChan  (reqChan),
    .reqType  (reqType),
    .reqWord  (reqWord),
    .reqCrcEn (reqCrcEn),
    .plData   (plData),
    .outData  (outData),
    .wcZero   (wcZero),
    .remOne   (remOne)
  );

endmodule

// File: rtl/pkt_asm_chk.sv
module pkt_asm_chk (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic        reqReady,
  input logic        reqLong,
  input logic [1:0]  reqChan,
  input logic [5:0]  reqType,
  input logic [15:0] reqWord,
  input logic        reqCrcEn,
  input logic        plValid,
  input logic        plReady,
  input logic [7:0]  plData,
  input logic        outValid,
  input logic        outReady,
  input logic [7:0]  outData,
  input logic        outLast
);

  localparam int IDX_W = 17;

  logic [IDX_W-1:0] idxQ;
  logic [7:0]       capDi;
  logic             capLong;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxQ    <= '0;
      capDi   <= '0;
      capLong <= 1'b0;
    end else begin
      if (reqValid && reqReady) begin
        capDi   <= {reqChan, reqType};
        capLong <= reqLong;
      end
      if (outValid && outReady) idxQ <= outLast ? '0 : idxQ + IDX_W'(1);
    end
  end

  // R1
  di_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && idxQ == '0 |-> outData == capDi);

  // R7
  ecc_top_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && idxQ == IDX_W'(3) |-> outData[7:6] == 2'b00);

  // R2
  short_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && idxQ == IDX_W'(3) && !capLong |-> outLast);

  // R8
  pay_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    plReady |-> capLong && idxQ >= IDX_W'(4) && outReady);

  // R9
  one_pkt_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !outValid && !plReady);

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outData) && $stable(outLast));

endmodule

bind pkt_asm_top pkt_asm_chk u_chk (.*);

// File: tb/pkt_asm_top_tb.sv
module pkt_asm_top_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqLong = 1'b0;
  logic [1:0]  reqChan = '0;
  logic [5:0]  reqType = '0;
  logic [15:0] reqWord = '0;
  logic        reqCrcEn = 1'b0;
  logic        plValid = 1'b0;
  logic        plReady;
  logic [7:0]  plData = '0;
  logic        outValid;
  logic        outReady = 1'b0;
  logic [7:0]  outData;
  logic        outLast;

  int  nChk = 0;
  int  nBad = 0;
  bit  doneF = 1'b0;
  logic [7:0] expB [0:127];
  logic [7:0] payB [0:127];
  int  expN;

  always #5 clk = ~clk;

  pkt_asm_top u_dut (.*);

  task automatic check(input bit ok, input string req, input int act, input int expv);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, expv);
    end
  endtask

  function automatic logic [7:0] refEcc(input logic [23:0] d);
    logic [7:0] p;
    p    = 8'h00;
    p[0] = ^{d[23:20], d[16], d[13], d[11:10], d[7], d[5:4], d[2:0]};
    p[1] = ^{d[23:20], d[17], d[14], d[12], d[10], d[8], d[6], d[4:3], d[1:0]};
    p[2] = ^{d[22:20], d[18], d[15], d[12:11], d[9], d[6:5], d[3:2], d[0]};
    p[3] = ^{d[23], d[21:19], d[15:13], d[9:7], d[3:1]};
    p[4] = ^{d[23:22], d[20:16], d[9:4]};
    p[5] = ^{d[23:21], d[19:10]};
    return p;
  endfunction

  function automatic logic [15:0] refCrc(input int n);
    logic [15:0] c;
    c = 16'hFFFF;
    for (int i = 0; i < n; i++) begin
      c = c ^ {8'h00, payB[i]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 16'h8408) : (c >> 1);
    end
    return c;
  endfunction

  function automatic string tagFor(input bit lng, input int idx, input int wc, input bit ce);
    if (idx == 0) return "R1";
    if (idx == 3) return "R7";
    if (!lng) return "R2";
    if (idx < 4 + wc) return "R3";
    if (!ce) return "R6";
    if (wc == 0) return "R5";
    return "R4";
  endfunction

  task automatic runPkt(input bit lng, input logic [1:0] ch, input logic [5:0] dt,
                        input logic [15:0] word, input bit ce, input int stallPct);
    logic [15:0] crc;
    int idx, pp, cyc, wc;
    bit holdF, plHold;
    logic [7:0] heldD;
    wc = lng ? int'(word) : 0;
    for (int i = 0; i < 128; i++) payB[i] = 8'($urandom);
    expB[0] = {ch, dt};
    expB[1] = word[7:0];
    expB[2] = word[15:8];
    expB[3] = refEcc({word, ch, dt});
    expN = 4;
    if (lng) begin
      for (int i = 0; i < wc; i++) expB[4 + i] = payB[i];
      crc = ce ? refCrc(wc) : 16'h0000;
      expB[4 + wc] = crc[7:0];
      expB[5 + wc] = crc[15:8];
      expN = 6 + wc;
    end
    @(negedge clk);
    reqValid = 1'b1; reqLong = lng; reqChan = ch; reqType = dt;
    reqWord = word; reqCrcEn = ce;
    #1;
    check(reqReady == 1'b1, "R9 idle ready", int'(reqReady), 1);
    @(posedge clk);
    idx = 0; pp = 0; cyc = 0; holdF = 0; plHold = 0; heldD = '0;
    while (idx < expN && cyc < 5000) begin
      @(negedge clk);
      reqType = ~dt; reqWord = ~word; reqLong = ~lng;
      outReady = (($urandom % 100) >= stallPct);
      plValid = plHold ? 1'b1 : (($urandom % 4) != 0);
      plData = payB[pp];
      #1;
      check(reqReady == 1'b0, "R9 busy", int'(reqReady), 0);
      if (holdF) check(outValid && outData == heldD, "R10 hold", int'(outData), int'(heldD));
      holdF = outValid && !outReady;
      heldD = outData;
      plHold = plValid && !plReady;
      if (outValid && outReady) begin
        check(outData == expB[idx], tagFor(lng, idx, wc, ce), int'(outData), int'(expB[idx]));
        check(outLast == (idx == expN - 1), lng ? "R3 last" : "R2 last",
              int'(outLast), int'(idx == expN - 1));
        idx++;
      end
      if (plValid && plReady) pp++;
      cyc++;
    end
    @(negedge clk);
    reqValid = 1'b0; plValid = 1'b0; outReady = 1'b0;
    check(cyc < 5000, "R3 completion", cyc, 0);
    check(pp == wc, "R8 consumed", pp, wc);
    #1;
    check(reqReady == 1'b1 && outValid == 1'b0, "R9 back to idle",
          int'({reqReady, outValid}), 2);
  endtask

  initial begin
    #1_000_000;
    if (!doneF) begin
      nBad++;
      $display("FAIL R9 watchdog act=hung exp=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    check(reqReady == 1'b1, "R9 reset ready", int'(reqReady), 1);
    check(outValid == 1'b0, "R9 reset valid", int'(outValid), 0);
    check(plReady == 1'b0, "R9 reset plReady", int'(plReady), 0);
    // directed corners
    runPkt(1'b0, 2'd1, 6'h15, 16'hA55A, 1'b1, 0);   // R2 short
    runPkt(1'b1, 2'd3, 6'h39, 16'd0, 1'b1, 0);      // R5 empty, CRC on
    runPkt(1'b1, 2'd2, 6'h29, 16'd0, 1'b0, 20);     // R6 empty, CRC off
    runPkt(1'b1, 2'd0, 6'h39, 16'd1, 1'b1, 0);      // R4 one byte
    runPkt(1'b1, 2'd1, 6'h0E, 16'd7, 1'b0, 30);     // R6 with payload
    runPkt(1'b1, 2'd2, 6'h3E, 16'd3, 1'b1, 60);     // R10 heavy stall
    runPkt(1'b0, 2'd3, 6'h3F, 16'hFFFF, 1'b1, 50);  // R7 all-ones header
    // constrained random
    for (int n = 0; n < 40; n++) begin
      bit lng;
      logic [15:0] w;
      lng = 1'($urandom);
      w = lng ? 16'($urandom % 48) : 16'($urandom);
      runPkt(lng, 2'($urandom), 6'($urandom), w, 1'($urandom), int'($urandom % 50));
    end
    doneF = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule